// File: doc/BRIEF.md
# MII Isolate and Collision-Test Gate

This block sits between the MAC-facing side of a Media Independent Interface (MII) and the transceiver core. It has two modes. In isolate mode it stops the MAC's transmit nibble, transmit enable and transmit error from reaching the core, and it pulls the output enable of every MII output pin low so that the pins float. In collision-test mode it ignores the core's real collision signal and drives the MII collision pin from the MAC's own transmit enable. The collision pin rises a fixed number of transmit-clock cycles after transmit enable goes high and falls one cycle after it goes low. The serial management pins do not pass through this block, so isolation never reaches them.

The block runs on the transmit clock that the core supplies, and it also drives that clock out on the MII transmit-clock pin. Both mode enables are sampled on the rising clock edge, the same edge that registers the transmit signals. A mode change therefore always lands on a nibble boundary. The MII has no back-pressure: transmit enable plays the part of a valid flag, and no ready exists, because the block accepts a nibble on every edge. Receive-side signals pass straight through as logic with no registers. Each MII output is paired with an output enable, and the pad ring builds the tri-state driver from that pair.

Top module: `mii_iso_gate`

## Requirements
- R1: While rst_n is low, every bit of mii_oe is 0, core_tx_en and core_tx_er are 0, core_txd is 0 and collision test is off.
- R2: isolate_en and coltest_en are sampled on each rising clk edge, and the sampled value governs the outputs from that edge until the next one.
- R3: After an edge that sampled isolate_en high, core_tx_en and core_tx_er are 0 and core_txd is all zeros, whatever the MAC drives.
- R4: After an edge that sampled isolate_en low, core_txd, core_tx_en and core_tx_er equal mac_txd, mac_tx_en and mac_tx_er as sampled at that edge.
- R5: mii_oe has one enable per pin group: bit 0 tx clock, 1 rx clock, 2 rx data valid, 3 rx error, 4 rx data nibble, 5 collision, 6 carrier sense. After an edge that sampled isolate_en high, all bits are 0. Otherwise all bits are 1.
- R6: mii_tx_clk equals clk. mii_rx_clk, mii_rx_dv, mii_rx_er, mii_rxd and mii_crs follow their core inputs without delay in every mode.
- R7: After an edge that sampled coltest_en low, mii_col equals core_col without delay.
- R8: After an edge that sampled coltest_en high, core_col is ignored. mii_col is 1 after the COL_RISE-th consecutive edge (default 2) that sampled mac_tx_en high with isolate_en low, which is well inside 512 bit times.
- R9: In collision test, mii_col is 0 after any edge that sampled mac_tx_en low or isolate_en high, which is one cycle and so within 4 bit times at nibble rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock from the core |
| rst_n | input | 1 | Asynchronous active-low reset |
| isolate_en | input | 1 | Isolate mode request |
| coltest_en | input | 1 | Collision-test mode request |
| mac_txd | input | DATA_W | Transmit nibble from the MAC |
| mac_tx_en | input | 1 | Transmit enable from the MAC |
| mac_tx_er | input | 1 | Transmit error from the MAC |
| core_txd | output | DATA_W | Registered transmit nibble to the core |
| core_tx_en | output | 1 | Registered transmit enable to the core |
| core_tx_er | output | 1 | Registered transmit error to the core |
| core_rx_clk | input | 1 | Receive clock from the core |
| core_rx_dv | input | 1 | Receive data valid from the core |
| core_rx_er | input | 1 | Receive error from the core |
| core_rxd | input | DATA_W | Receive nibble from the core |
| core_col | input | 1 | Collision detected by the core |
| core_crs | input | 1 | Carrier sense from the core |
| mii_tx_clk | output | 1 | Transmit clock pin value |
| mii_rx_clk | output | 1 | Receive clock pin value |
| mii_rx_dv | output | 1 | Receive data valid pin value |
| mii_rx_er | output | 1 | Receive error pin value |
| mii_rxd | output | DATA_W | Receive nibble pin value |
| mii_col | output | 1 | Collision pin value |
| mii_crs | output | 1 | Carrier sense pin value |
| mii_oe | output | 7 | Per-group output enables, mapping as in R5 |

## Verification
The transmit outputs, the output enables and the mode selection all change exactly one edge after the inputs that cause them. The collision pin in test mode rises on the COL_RISE-th consecutive edge with transmit enabled and falls on the first edge without it. The receive pins and the pass-through collision pin have no delay. The bench changes inputs on the falling edge, and its reference model advances on the rising edge. It compares every output at the following falling edge. At that point each registered result has had exactly one edge, and each combinational result reflects the inputs just driven.

// File: rtl/mii_iso_pkg.sv
package mii_iso_pkg;
  // Output-enable bit positions, one per MII output pin group
  localparam int unsigned OE_TXCLK = 0;
  localparam int unsigned OE_RXCLK = 1;
  localparam int unsigned OE_RXDV  = 2;
  localparam int unsigned OE_RXER  = 3;
  localparam int unsigned OE_RXD   = 4;
  localparam int unsigned OE_COL   = 5;
  localparam int unsigned OE_CRS   = 6;
  localparam int unsigned OE_W     = 7;

  // Default number of consecutive enabled edges before test collision
  localparam int unsigned COL_RISE_DEF = 2;
endpackage

// File: rtl/mii_iso_ctrl.sv
module mii_iso_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic isolate_en,
  input  logic coltest_en,
  output logic iso_q,
  output logic ct_q
);
  // Reset lands in the isolated state so the pins float until the
  // first post-reset edge samples the real request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iso_q <= 1'b1;
      ct_q  <= 1'b0;
    end else begin
      iso_q <= isolate_en;
      ct_q  <= coltest_en;
    end
  end
endmodule

// File: rtl/mii_iso_txgate.sv
module mii_iso_txgate #(
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              isolate_en,
  input  logic [DATA_W-1:0] mac_txd,
  input  logic              mac_tx_en,
  input  logic              mac_tx_er,
  output logic [DATA_W-1:0] core_txd,
  output logic              core_tx_en,
  output logic              core_tx_er
);
  logic [DATA_W-1:0] txd_n;
  logic              en_n;
  logic              er_n;

  // Gate on the same edge that updates the isolate register
  always_comb begin
    txd_n = isolate_en ? '0   : mac_txd;
    en_n  = isolate_en ? 1'b0 : mac_tx_en;
    er_n  = isolate_en ? 1'b0 : mac_tx_er;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_txd   <= '0;
      core_tx_en <= 1'b0;
      core_tx_er <= 1'b0;
    end else begin
      core_txd   <= txd_n;
      core_tx_en <= en_n;
      core_tx_er <= er_n;
    end
  end

  assert_tx_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    isolate_en |=> (!core_tx_en && !core_tx_er && core_txd == '0));

  assert_tx_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !isolate_en |=> (core_txd == $past(mac_txd) &&
                     core_tx_en == $past(mac_tx_en) &&
                     core_tx_er == $past(mac_tx_er)));
endmodule

// File: rtl/mii_iso_coltest.sv
module mii_iso_coltest #(
  parameter int unsigned RISE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_s,
  output logic test_col
);
  localparam int unsigned HIST_W = (RISE > 1) ? RISE - 1 : 1;
  localparam int unsigned CW     = $clog2(RISE + 1);

  generate
    if (RISE > 1) begin : g_hist
      logic [HIST_W-1:0] hist;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[HIST_W-2+((HIST_W>1)?0:1):0], en_s} ;
      end
      // Enable now and on every one of the previous RISE-1 edges
      assign test_col = en_s & (&hist);
    end else begin : g_direct
      assign test_col = en_s;
    end
  endgenerate

  // Checker: consecutive-enable run length, counted independently
  logic [CW-1:0] run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   run_cnt <= '0;
    else if (!en_s)               run_cnt <= '0;
    else if (run_cnt < CW'(RISE)) run_cnt <= run_cnt + 1'b1;
  end

  // R8 rise latency and R9 release both follow from this relation
  assert_col_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    test_col == (en_s && (run_cnt >= CW'(RISE - 1))));
endmodule

// File: rtl/mii_iso_pins.sv
module mii_iso_pins
  import mii_iso_pkg::*;
#(
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk,
  input  logic              iso_q,
  input  logic              ct_q,
  input  logic              test_col,
  input  logic              core_rx_clk,
  input  logic              core_rx_dv,
  input  logic              core_rx_er,
  input  logic [DATA_W-1:0] core_rxd,
  input  logic              core_col,
  input  logic              core_crs,
  output logic              mii_tx_clk,
  output logic              mii_rx_clk,
  output logic              mii_rx_dv,
  output logic              mii_rx_er,
  output logic [DATA_W-1:0] mii_rxd,
  output logic              mii_col,
  output logic              mii_crs,
  output logic [OE_W-1:0]   mii_oe
);
  assign mii_tx_clk = clk;
  assign mii_rx_clk = core_rx_clk;
  assign mii_rx_dv  = core_rx_dv;
  assign mii_rx_er  = core_rx_er;
  assign mii_rxd    = core_rxd;
  assign mii_crs    = core_crs;
  assign mii_col    = ct_q ? test_col : core_col;

  generate
    for (genvar gi = 0; gi < OE_W; gi++) begin : g_oe
      assign mii_oe[gi] = ~iso_q;
    end
  endgenerate
endmodule

// File: rtl/mii_iso_gate.sv
module mii_iso_gate
  import mii_iso_pkg::*;
#(
  parameter int unsigned DATA_W   = 4,
  parameter int unsigned COL_RISE = COL_RISE_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              isolate_en,
  input  logic              coltest_en,
  input  logic [DATA_W-1:0] mac_txd,
  input  logic              mac_tx_en,
  input  logic              mac_tx_er,
  output logic [DATA_W-1:0] core_txd,
  output logic              core_tx_en,
  output logic              core_tx_er,
  input  logic              core_rx_clk,
  input  logic              core_rx_dv,
  input  logic              core_rx_er,
  input  logic [DATA_W-1:0] core_rxd,
  input  logic              core_col,
  input  logic              core_crs,
  output logic              mii_tx_clk,
  output logic              mii_rx_clk,
  output logic              mii_rx_dv,
  output logic              mii_rx_er,
  output logic [DATA_W-1:0] mii_rxd,
  output logic              mii_col,
  output logic              mii_crs,
  output logic [OE_W-1:0]   mii_oe
);
  logic iso_q;
  logic ct_q;
  logic test_col;

  mii_iso_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .isolate_en (isolate_en),
    .coltest_en (coltest_en),
    .iso_q      (iso_q),
    .ct_q       (ct_q)
  );

  mii_iso_txgate #(.DATA_W(DATA_W)) u_txgate (
    .clk        (clk),
    .rst_n      (rst_n),
    .isolate_en (isolate_en),
    .mac_txd    (mac_txd),
    .mac_tx_en  (mac_tx_en),
    .mac_tx_er  (mac_tx_er),
    .core_txd   (core_txd),
    .core_tx_en (core_tx_en),
    .core_tx_er (core_tx_er)
  );

  mii_iso_coltest #(.RISE(COL_RISE)) u_coltest (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_s     (core_tx_en),
    .test_col (test_col)
  );

  mii_iso_pins #(.DATA_W(DATA_W)) u_pins (
    .clk         (clk),
    .iso_q       (iso_q),
    .ct_q        (ct_q),
    .test_col    (test_col),
    .core_rx_clk (core_rx_clk),
    .core_rx_dv  (core_rx_dv),
    .core_rx_er  (core_rx_er),
    .core_rxd    (core_rxd),
    .core_col    (core_col),
    .core_crs    (core_crs),
    .mii_tx_clk  (mii_tx_clk),
    .mii_rx_clk  (mii_rx_clk),
    .mii_rx_dv   (mii_rx_dv),
    .mii_rx_er   (mii_rx_er),
    .mii_rxd     (mii_rxd),
    .mii_col     (mii_col),
    .mii_crs     (mii_crs),
    .mii_oe      (mii_oe)
  );

  // R2 and R5: enables follow the sampled isolate request one edge later
  assert_oe_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    isolate_en |=> (mii_oe == '0));

  assert_oe_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !isolate_en |=> (&mii_oe));

  assert_col_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !coltest_en |=> (mii_col == core_col));

  assert_col_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (coltest_en && (!mac_tx_en || isolate_en)) |=> !mii_col);
endmodule

// File: tb/mii_iso_gate_test.sv
module mii_iso_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 4;
  localparam int RISE       = 2;
  localparam int OEW        = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          isolate_en = 1'b0;
  logic          coltest_en = 1'b0;
  logic [W-1:0]  mac_txd = '0;
  logic          mac_tx_en = 1'b0;
  logic          mac_tx_er = 1'b0;
  logic [W-1:0]  core_txd;
  logic          core_tx_en, core_tx_er;
  logic          core_rx_clk = 1'b0, core_rx_dv = 1'b0, core_rx_er = 1'b0;
  logic [W-1:0]  core_rxd = '0;
  logic          core_col = 1'b0, core_crs = 1'b0;
  logic          mii_tx_clk, mii_rx_clk, mii_rx_dv, mii_rx_er, mii_col, mii_crs;
  logic [W-1:0]  mii_rxd;
  logic [OEW-1:0] mii_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Reference model state
  bit m_iso = 1'b1, m_ct = 1'b0, m_en = 1'b0, m_er = 1'b0;
  int m_txd = 0;
  int m_run = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mii_iso_gate #(.DATA_W(W), .COL_RISE(RISE)) uut (
    .clk(clk), .rst_n(rst_n), .isolate_en(isolate_en), .coltest_en(coltest_en),
    .mac_txd(mac_txd), .mac_tx_en(mac_tx_en), .mac_tx_er(mac_tx_er),
    .core_txd(core_txd), .core_tx_en(core_tx_en), .core_tx_er(core_tx_er),
    .core_rx_clk(core_rx_clk), .core_rx_dv(core_rx_dv), .core_rx_er(core_rx_er),
    .core_rxd(core_rxd), .core_col(core_col), .core_crs(core_crs),
    .mii_tx_clk(mii_tx_clk), .mii_rx_clk(mii_rx_clk), .mii_rx_dv(mii_rx_dv),
    .mii_rx_er(mii_rx_er), .mii_rxd(mii_rxd), .mii_col(mii_col),
    .mii_crs(mii_crs), .mii_oe(mii_oe)
  );

  // Behavioural model: advances on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_iso = 1'b1; m_ct = 1'b0; m_en = 1'b0; m_er = 1'b0; m_txd = 0; m_run = 0;
    end else begin
      m_iso = isolate_en;
      m_ct  = coltest_en;
      m_en  = isolate_en ? 1'b0 : mac_tx_en;
      m_er  = isolate_en ? 1'b0 : mac_tx_er;
      m_txd = isolate_en ? 0 : int'(mac_txd);
      m_run = m_en ? m_run + 1 : 0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    int exp_oe;
    int exp_col;
    exp_oe = m_iso ? 0 : (1 << OEW) - 1;
    if (!rst_n) begin
      chk("R1", "oe in reset", int'(mii_oe), 0);
      chk("R1", "tx in reset", int'({core_tx_en, core_tx_er, core_txd}), 0);
      chk("R1", "col in reset", int'(mii_col), int'(core_col));
    end else begin
      chk("R5", "oe", int'(mii_oe), exp_oe);
      if (m_iso) chk("R3", "tx blocked", int'({core_tx_en, core_tx_er, core_txd}), 0);
      else       chk("R4", "tx forward", int'({core_tx_en, core_tx_er, core_txd}),
                     int'({m_en, m_er, 4'(m_txd)}));
      if (m_ct) begin
        exp_col = (m_run >= RISE) ? 1 : 0;
        chk(m_run == 0 ? "R9" : "R8", "test col", int'(mii_col), exp_col);
      end else begin
        chk("R7", "col pass", int'(mii_col), int'(core_col));
      end
      chk("R2", "mode applied", int'(mii_oe[0]), m_iso ? 0 : 1);
    end
    chk("R6", "rx pins", int'({mii_tx_clk, mii_rx_clk, mii_rx_dv, mii_rx_er, mii_rxd, mii_crs}),
        int'({clk, core_rx_clk, core_rx_dv, core_rx_er, core_rxd, core_crs}));
  endtask

  task automatic step(input bit iso, input bit ct, input bit en, input bit er, input int d);
    @(negedge clk);
    check_all();
    isolate_en  = iso;
    coltest_en  = ct;
    mac_tx_en   = en;
    mac_tx_er   = er;
    mac_txd     = W'(d);
    core_rx_clk = 1'($urandom);
    core_rx_dv  = 1'($urandom);
    core_rx_er  = 1'($urandom);
    core_rxd    = W'($urandom);
    core_col    = 1'($urandom);
    core_crs    = 1'($urandom);
  endtask

  initial begin
    // R1: reset state
    repeat (3) step(1'b0, 1'b0, 1'b1, 1'b1, 5);
    @(negedge clk);
    rst_n = 1'b1;
    // R4, R6, R7: plain traffic
    for (int i = 0; i < 40; i++)
      step(1'b0, 1'b0, 1'($urandom), 1'($urandom), int'($urandom % 16));
    // R3, R5: isolate in the middle of a frame, then release
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b1, 1'($urandom), int'($urandom % 16));
    for (int i = 0; i < 5; i++)  step(1'b0, 1'b0, 1'b1, 1'b0, i);
    // R8, R9: collision-test pulses of length 1, 2 and 10
    for (int len = 1; len <= 10; len = (len == 1) ? 2 : 10) begin
      for (int i = 0; i < len; i++) step(1'b0, 1'b1, 1'b1, 1'b0, i);
      for (int i = 0; i < 4; i++)   step(1'b0, 1'b1, 1'b0, 1'b0, 0);
      if (len == 10) break;
    end
    // R9: isolate cuts an active test collision
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, 1'b0, 0);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b0, 0);
    // R2: all modes toggled randomly
    for (int i = 0; i < 300; i++)
      step(($urandom % 5) == 0, 1'($urandom), ($urandom % 4) != 0, 1'($urandom),
           int'($urandom % 16));
    @(negedge clk);
    check_all();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule